// File: doc/BRIEF.md
# Secondary Core Launch Sequencer

This block starts a secondary processor by sending it a fixed six-word command over a pair of mailbox FIFOs. It pushes one word at a time into the outgoing FIFO and waits for the partner to echo that word back on the incoming FIFO. The words are two zeros, a one, the vector table base, the initial stack pointer and the entry address, in that order. A correct echo moves on to the next word. Any wrong echo sends the sequence back to the first word.

Before any zero word goes out, the sequencer discards everything waiting in the incoming FIFO. It then raises a one-cycle wake event, because the partner may be stalled waiting for FIFO space. The sequencer also owns the mailbox receive-interrupt enable bit. It holds this bit low for the whole handshake and gives it back when the handshake ends.

A host pulses `start` with the three launch parameters on the inputs. It then watches `busy` and waits for the one-cycle `done` pulse.

Top module: `core_launch_seq`

## Requirements
- R1: After an accepted start, the words pushed into the outgoing FIFO are 0, 0, 1, vector base, stack pointer and entry address, in that order, when every echo matches.
- R2: `tx_push` is asserted only in a cycle where `tx_ready` is high.
- R3: After each push, the sequencer pushes nothing more until it has popped one incoming word and compared it with the word it sent.
- R4: If an echo differs from the word sent, the next word pushed is the first word (0), and the full sequence is resent from there.
- R5: When a zero word is pushed, the incoming FIFO is empty: all entries present beforehand have been popped and discarded.
- R6: Exactly one single-cycle `wake` pulse precedes every push of a zero word. This includes a launch parameter whose value is zero. No wake pulse precedes a push of a non-zero word.
- R7: `rx_pop` is asserted only in a cycle where `rx_valid` is high.
- R8: The sequence completes only after all six words have been echoed correctly. `done` is then high for exactly one cycle, with `busy` already low.
- R9: While `busy` is high, `irq_en` is low.
- R10: The three launch parameters are captured when start is accepted. A `start` pulse or parameter change while busy has no effect on the words sent.
- R11: When the sequence finishes, `irq_en` returns to the value it had at start, or to the value of the last `irq_wr` write made during the handshake. A write while idle updates `irq_en` on the next cycle.
- R12: After reset, `busy`, `done`, `wake`, `tx_push`, `rx_pop` and `irq_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a launch (ignored while busy) |
| vec_base | input | WORD_W | Vector table base for the secondary core |
| stack_top | input | WORD_W | Initial stack pointer |
| entry_addr | input | WORD_W | Entry address |
| irq_wr | input | 1 | Host write strobe for the receive-interrupt enable |
| irq_wdata | input | 1 | Value written by the host |
| irq_en | output | 1 | Effective mailbox receive-interrupt enable |
| busy | output | 1 | Handshake in progress |
| done | output | 1 | One-cycle completion pulse |
| wake | output | 1 | One-cycle event pulse sent before a zero word |
| tx_push | output | 1 | Push strobe to the outgoing FIFO |
| tx_data | output | WORD_W | Word being offered to the outgoing FIFO |
| tx_ready | input | 1 | Outgoing FIFO has space |
| rx_pop | output | 1 | Pop strobe to the incoming FIFO |
| rx_data | input | WORD_W | Head of the incoming FIFO |
| rx_valid | input | 1 | Incoming FIFO not empty |

## Verification
The bench preloads stale words into the incoming FIFO before a launch. A sequencer that skipped the drain would take a stale word as the echo and restart, or push a zero with data still queued. Single echoes are corrupted at the stack-pointer word and at the second zero. A design that resumed where it failed, instead of going back to word 0, would send the wrong number of words. Back-pressure on `tx_ready` exposes pushes made without space. A zero-valued vector base catches a wake pulse that was tied to a position in the sequence rather than to the word's value. Restarts while busy, parameter changes after start, and host writes to the interrupt enable during the handshake check that captured state is not overwritten.

// File: rtl/launch_pkg.sv
package launch_pkg;
   localparam int NUM_WORDS = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_DRAIN,
      ST_WAKE,
      ST_PUSH,
      ST_ECHO
   } seq_state_t;
endpackage

// File: rtl/launch_word_sel.sv
module launch_word_sel #(
   parameter int WORD_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] vec_q,
   input  logic [WORD_W-1:0] sp_q,
   input  logic [WORD_W-1:0] entry_q,
   output logic [WORD_W-1:0] word,
   output logic              word_zero
);
   always_comb begin
      case (idx)
         IDX_W'(2): word = WORD_W'(1);
         IDX_W'(3): word = vec_q;
         IDX_W'(4): word = sp_q;
         IDX_W'(5): word = entry_q;
         default:   word = '0;
      endcase
   end

   assign word_zero = (word == '0);
endmodule

// File: rtl/launch_seq_fsm.sv
module launch_seq_fsm
   import launch_pkg::*;
#(
   parameter int IDX_W    = 3,
   parameter int LAST_IDX = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             word_zero,
   input  logic             echo_match,
   input  logic             tx_ready,
   input  logic             rx_valid,
   output logic [IDX_W-1:0] idx,
   output logic             accept,
   output logic             finish,
   output logic             tx_push,
   output logic             rx_pop,
   output logic             wake,
   output logic             busy,
   output logic             done
);
   seq_state_t       st_q, st_d;
   logic [IDX_W-1:0] idx_d;

   always_comb begin
      st_d    = st_q;
      idx_d   = idx;
      accept  = 1'b0;
      finish  = 1'b0;
      tx_push = 1'b0;
      rx_pop  = 1'b0;
      wake    = 1'b0;
      case (st_q)
         ST_IDLE: if (start) begin
            accept = 1'b1;
            idx_d  = '0;
            st_d   = ST_SEL;
         end
         ST_SEL:   st_d = word_zero ? ST_DRAIN : ST_PUSH;
         ST_DRAIN: begin
            rx_pop = rx_valid;
            if (!rx_valid) st_d = ST_WAKE;
         end
         ST_WAKE: begin
            wake = 1'b1;
            st_d = ST_PUSH;
         end
         ST_PUSH: begin
            tx_push = tx_ready;
            if (tx_ready) st_d = ST_ECHO;
         end
         ST_ECHO: if (rx_valid) begin
            rx_pop = 1'b1;
            if (!echo_match) begin
               idx_d = '0;
               st_d  = ST_SEL;
            end else if (idx == IDX_W'(LAST_IDX)) begin
               finish = 1'b1;
               st_d   = ST_IDLE;
            end else begin
               idx_d = idx + 1'b1;
               st_d  = ST_SEL;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         idx  <= '0;
         done <= 1'b0;
      end else begin
         st_q <= st_d;
         idx  <= idx_d;
         done <= finish;
      end
   end

   assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/core_launch_seq.sv
module core_launch_seq
   import launch_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] vec_base,
   input  logic [WORD_W-1:0] stack_top,
   input  logic [WORD_W-1:0] entry_addr,
   input  logic              irq_wr,
   input  logic              irq_wdata,
   output logic              irq_en,
   output logic              busy,
   output logic              done,
   output logic              wake,
   output logic              tx_push,
   output logic [WORD_W-1:0] tx_data,
   input  logic              tx_ready,
   output logic              rx_pop,
   input  logic [WORD_W-1:0] rx_data,
   input  logic              rx_valid
);
   localparam int IDX_W    = $clog2(NUM_WORDS);
   localparam int LAST_IDX = NUM_WORDS - 1;

   generate
      if (WORD_W < 8) begin : g_bad_width
         $error("core_launch_seq: WORD_W must be at least 8");
      end
   endgenerate

   logic [WORD_W-1:0] vec_q, sp_q, entry_q, word;
   logic [IDX_W-1:0]  idx;
   logic              word_zero, accept, finish;
   logic              irq_q, irq_saved;

   launch_word_sel #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_sel (
      .idx(idx), .vec_q(vec_q), .sp_q(sp_q), .entry_q(entry_q),
      .word(word), .word_zero(word_zero)
   );

   launch_seq_fsm #(.IDX_W(IDX_W), .LAST_IDX(LAST_IDX)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start),
      .word_zero(word_zero), .echo_match(rx_data == word),
      .tx_ready(tx_ready), .rx_valid(rx_valid),
      .idx(idx), .accept(accept), .finish(finish),
      .tx_push(tx_push), .rx_pop(rx_pop), .wake(wake),
      .busy(busy), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q   <= '0;
         sp_q    <= '0;
         entry_q <= '0;
      end else if (accept) begin
         vec_q   <= vec_base;
         sp_q    <= stack_top;
         entry_q <= entry_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q     <= 1'b0;
         irq_saved <= 1'b0;
      end else if (accept) begin
         irq_saved <= irq_wr ? irq_wdata : irq_q;
         irq_q     <= 1'b0;
      end else if (finish) begin
         irq_q <= irq_wr ? irq_wdata : irq_saved;
      end else if (busy) begin
         if (irq_wr) irq_saved <= irq_wdata;
      end else if (irq_wr) begin
         irq_q <= irq_wdata;
      end
   end

   assign irq_en  = irq_q;
   assign tx_data = word;
endmodule

// File: rtl/core_launch_seq_chk.sv
module core_launch_seq_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_en,
   input logic              busy,
   input logic              done,
   input logic              wake,
   input logic              tx_push,
   input logic [WORD_W-1:0] tx_data,
   input logic              tx_ready,
   input logic              rx_pop,
   input logic              rx_valid
);
   // R2
   push_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> tx_ready);
   // R3
   one_push_per_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |=> !tx_push);
   // R5
   zero_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && tx_data == '0) |-> !rx_valid);
   // R6
   wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake);
   // R6
   wake_zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (tx_data == '0 && !tx_push));
   // R7
   pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> rx_valid);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !irq_en);
endmodule

bind core_launch_seq core_launch_seq_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .busy(busy), .done(done),
   .wake(wake), .tx_push(tx_push), .tx_data(tx_data), .tx_ready(tx_ready),
   .rx_pop(rx_pop), .rx_valid(rx_valid)
);

// File: tb/sim_core_launch_seq.sv
`timescale 1ns/1ps
module sim_core_launch_seq;
   localparam int W = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, irq_wr = 1'b0, irq_wdata = 1'b0;
   logic [W-1:0] vec_base = '0, stack_top = '0, entry_addr = '0;
   logic irq_en, busy, done, wake, tx_push, rx_pop;
   logic [W-1:0] tx_data, rx_data;
   logic rx_valid, tx_ready = 1'b1;

   always #4 clk = ~clk;

   core_launch_seq #(.WORD_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_base(vec_base),
      .stack_top(stack_top), .entry_addr(entry_addr), .irq_wr(irq_wr),
      .irq_wdata(irq_wdata), .irq_en(irq_en), .busy(busy), .done(done),
      .wake(wake), .tx_push(tx_push), .tx_data(tx_data), .tx_ready(tx_ready),
      .rx_pop(rx_pop), .rx_data(rx_data), .rx_valid(rx_valid)
   );

   int checks = 0, fails = 0;

   // partner model: incoming FIFO plus echo logic
   logic [W-1:0] mem [16];
   int head = 0, cnt = 0;
   int stale_req = 0, corrupt_at = -1, throttle = 0;
   logic [W-1:0] plog [32];
   int npush = 0, nwake = 0, bad_zero = 0, bad_wake = 0;
   bit wake_seen = 0;

   assign rx_valid = (cnt > 0);
   assign rx_data  = mem[head];

   always @(posedge clk) begin
      int h, c;
      logic [W-1:0] v;
      h = head; c = cnt;
      if (rx_pop) begin h = (h + 1) % 16; c = c - 1; end
      if (wake) begin
         nwake = nwake + 1;
         wake_seen = 1;
      end
      if (tx_push) begin
         if (tx_data == '0 && (c != 0 || !wake_seen)) bad_zero = bad_zero + 1;
         if (tx_data != '0 && wake_seen) bad_wake = bad_wake + 1;
         wake_seen = 0;
         if (npush < 32) plog[npush] = tx_data;
         v = tx_data;
         if (npush == corrupt_at) begin v = v ^ 1; corrupt_at = -1; end
         npush = npush + 1;
         mem[(h + c) % 16] <= v;
         c = c + 1;
      end else if (stale_req > 0) begin
         mem[(h + c) % 16] <= 32'hA5A5_0000 + W'(stale_req);
         c = c + 1;
         stale_req = stale_req - 1;
      end
      head <= h;
      cnt  <= c;
      tx_ready <= (throttle != 0) ? ~tx_ready : 1'b1;
   end

   logic [W-1:0] exp_w [32];
   int nexp;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   task automatic clear_log();
      npush = 0; nwake = 0; bad_zero = 0; bad_wake = 0; wake_seen = 0;
   endtask

   task automatic set_exp_seq(input logic [W-1:0] v, input logic [W-1:0] s, input logic [W-1:0] e);
      exp_w[nexp]   = 0; exp_w[nexp+1] = 0; exp_w[nexp+2] = 1;
      exp_w[nexp+3] = v; exp_w[nexp+4] = s; exp_w[nexp+5] = e;
      nexp += 6;
   endtask

   task automatic pulse_start(input logic [W-1:0] v, input logic [W-1:0] s, input logic [W-1:0] e);
      @(negedge clk);
      vec_base = v; stack_top = s; entry_addr = e; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 2000) begin @(negedge clk); n++; end
      chk(done, req, 0, 1);
      chk(!busy, "R8 busy low at done", busy, 0);
      @(negedge clk);
      chk(!done, "R8 done one cycle", done, 0);
   endtask

   task automatic cmp_log(input string req);
      chk(npush == nexp, req, npush, nexp);
      for (int i = 0; i < nexp && i < npush; i++)
         chk(plog[i] == exp_w[i], req, plog[i], exp_w[i]);
      chk(bad_zero == 0, "R5 drain and wake before zero", bad_zero, 0);
      chk(bad_wake == 0, "R6 no wake before non-zero", bad_wake, 0);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !wake, "R12 reset status", {busy, done, wake}, 0);
      chk(!tx_push && !rx_pop && !irq_en, "R12 reset strobes", {tx_push, rx_pop, irq_en}, 0);
   endtask

   task automatic t_basic();
      @(negedge clk); irq_wr = 1; irq_wdata = 1;
      @(negedge clk); irq_wr = 0;
      chk(irq_en == 1, "R11 idle write", irq_en, 1);
      clear_log(); nexp = 0;
      set_exp_seq(32'h1000_0000, 32'h2004_2000, 32'h1000_01C1);
      pulse_start(32'h1000_0000, 32'h2004_2000, 32'h1000_01C1);
      chk(busy && !irq_en, "R9 masked while busy", {busy, irq_en}, 2);
      wait_done("R8 completes");
      cmp_log("R1 word order");
      chk(nwake == 2, "R6 two wakes", nwake, 2);
      chk(irq_en == 1, "R11 restored", irq_en, 1);
   endtask

   task automatic t_stale_throttle();
      stale_req = 3; throttle = 1;
      repeat (5) @(negedge clk);
      clear_log(); nexp = 0;
      set_exp_seq(32'h0000_4000, 32'h2000_0800, 32'h0000_0101);
      pulse_start(32'h0000_4000, 32'h2000_0800, 32'h0000_0101);
      wait_done("R5 completes with stale data");
      cmp_log("R2 R5 order under backpressure");
      chk(nwake == 2, "R6 wakes with stale", nwake, 2);
      throttle = 0;
   endtask

   task automatic t_mismatch_sp();
      clear_log(); nexp = 0; corrupt_at = 4;
      exp_w[0] = 0; exp_w[1] = 0; exp_w[2] = 1; exp_w[3] = 32'h11; exp_w[4] = 32'h22;
      nexp = 5;
      set_exp_seq(32'h11, 32'h22, 32'h33);
      pulse_start(32'h11, 32'h22, 32'h33);
      wait_done("R4 completes after restart");
      cmp_log("R4 restart from word 0");
      chk(nwake == 4, "R4 R6 wakes after restart", nwake, 4);
   endtask

   task automatic t_busy_restart_ignored();
      clear_log(); nexp = 0; corrupt_at = 1;
      exp_w[0] = 0; exp_w[1] = 0; nexp = 2;
      set_exp_seq(32'h51, 32'h52, 32'h53);
      pulse_start(32'h51, 32'h52, 32'h53);
      repeat (3) @(negedge clk);
      pulse_start(32'h91, 32'h92, 32'h93);
      vec_base = 32'hDEAD; stack_top = 32'hBEEF; entry_addr = 32'hCAFE;
      wait_done("R10 completes");
      cmp_log("R10 R4 start ignored, params held");
      chk(nwake == 4, "R6 wakes on zero restart", nwake, 4);
   endtask

   task automatic t_zero_param_irq();
      @(negedge clk); irq_wr = 1; irq_wdata = 0;
      @(negedge clk); irq_wr = 0;
      clear_log(); nexp = 0;
      set_exp_seq(32'h0, 32'h77, 32'h88);
      pulse_start(32'h0, 32'h77, 32'h88);
      @(negedge clk); irq_wr = 1; irq_wdata = 1;
      @(negedge clk); irq_wr = 0;
      chk(irq_en == 0, "R9 write while busy held off", irq_en, 0);
      wait_done("R6 completes with zero vector");
      cmp_log("R6 zero vector order");
      chk(nwake == 3, "R6 wake before zero parameter", nwake, 3);
      chk(irq_en == 1, "R11 busy write applied at end", irq_en, 1);
   endtask

   bit finished = 0;

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_stale_throttle();
      t_mismatch_sp();
      t_busy_restart_ignored();
      t_zero_param_irq();
      finished = 1;
   end

   initial begin
      int cyc = 0;
      while (!finished && cyc < 100000) begin @(negedge clk); cyc++; end
      if (!finished) chk(0, "watchdog", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule